// File: doc/BRIEF.md
# Posted-Write System Bus Bridge

This block joins a local processor memory bus to a shared system bus. Each request the local side accepts becomes one entry in an in-order transaction queue. An entry holds the write data, the address and a control word. The control word is the direction bit plus a nine-bit attribute field that is passed through unchanged. The system-bus master port drains the queue one entry at a time, using a ready/error handshake.

Writes are posted. The local master receives its acknowledge in the same cycle the entry is pushed, and the system-bus transfer happens later. Any error the system bus reports for a posted write is dropped. A read also travels through the queue, so it cannot overtake earlier writes. Its returned data does not enter the queue: it is captured from the system bus and handed straight back to the local master, which stays stalled until then. A read error comes back as an error response. When the queue is full, new requests get wait states and are not lost.

Top module: `sysbus_post_bridge`

## Requirements
- R1: While reset is asserted, and right after it is released, `sreq_o`, `lack_o` and `lerr_o` are low.
- R2: A local write offered while the queue has a free slot and no read is outstanding is acknowledged combinationally in that same cycle. `lerr_o` is low with that acknowledge.
- R3: The queue holds DEPTH (default 16) entries. While the system bus stalls, 16 writes are accepted and a 17th sees `lack_o` low. It is accepted once a slot frees, and is never dropped.
- R4: System-bus transfers go out in acceptance order. Each one carries the local address, the attribute and the direction (`swrite_o`=1 for write), and the local write data when it is a write.
- R5: A transfer offered with `sreq_o` high stays offered with stable address, data, attribute and direction until a cycle in which `sready_i` is high. That cycle completes it.
- R6: A system-bus error on a posted write never produces `lerr_o` or an extra `lack_o` on the local port.
- R7: A read is acknowledged only after every earlier entry has completed and its own transfer has completed. `lack_o` rises in the cycle after that completing edge, and `lrdata_o` carries the `srdata_i` value sampled at that edge.
- R8: If `serr_i` is high when a read transfer completes, `lerr_o` is high together with that read's `lack_o`. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lreq_i | input | 1 | Local request, held until acknowledged |
| lwrite_i | input | 1 | Local direction, 1 = write |
| laddr_i | input | ADDR_W | Local address |
| lwdata_i | input | DATA_W | Local write data, ignored for reads |
| lattr_i | input | ATTR_W | Transfer attributes passed to the system bus |
| lack_o | output | 1 | Local acknowledge, one cycle |
| lerr_o | output | 1 | Local error response, valid with lack_o |
| lrdata_o | output | DATA_W | Read data, valid with a read acknowledge |
| sreq_o | output | 1 | System-bus transfer request |
| swrite_o | output | 1 | System-bus direction, 1 = write |
| saddr_o | output | ADDR_W | System-bus address |
| swdata_o | output | DATA_W | System-bus write data |
| sattr_o | output | ATTR_W | System-bus attributes |
| sready_i | input | 1 | System-bus completion for the offered transfer |
| serr_i | input | 1 | System-bus error, valid with sready_i |
| srdata_i | input | DATA_W | System-bus read data, valid with sready_i |

## Verification
The assertions assume the local master holds `lreq_i` and its fields steady until `lack_o` and lowers the request in the following cycle. They also assume the system bus drives `serr_i` and `srdata_i` only as meaningful values in a cycle where `sready_i` is high. The stimulus keeps to this: every request is raised on a falling edge and dropped on the falling edge after its acknowledge. The system-bus model derives data and error from the offered address in each cycle. It switches between always-ready, fully stalled and alternate-cycle ready, so offered transfers are held across stalls while full-queue wait states and read ordering are exercised.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  typedef enum logic [1:0] {
    LS_IDLE    = 2'd0,
    LS_RD_WAIT = 2'd1,
    LS_RD_DONE = 2'd2
  } lstate_e;

  // direction bit position inside the control word of an entry
  localparam int unsigned CTL_WR_BIT = 0;
endpackage

// File: rtl/sbb_queue.sv
module sbb_queue #(
  parameter int unsigned W     = 74,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sbb_local_port.sv
module sbb_local_port
  import sbb_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 9,
  parameter int unsigned EW = DW + AW + TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lreq_i,
  input  logic          lwrite_i,
  input  logic [AW-1:0] laddr_i,
  input  logic [DW-1:0] lwdata_i,
  input  logic [TW-1:0] lattr_i,
  output logic          lack_o,
  output logic          lerr_o,
  output logic [DW-1:0] lrdata_o,
  input  logic          q_full_i,
  output logic          push_o,
  output logic [EW-1:0] entry_o,
  input  logic          rd_done_i,
  input  logic          rd_err_i,
  input  logic [DW-1:0] rd_data_i
);
  lstate_e       st_q, st_d;
  logic          err_q;
  logic [DW-1:0] data_q;
  logic          accept;
  logic [TW:0]   ctrl;

  // no new request while a read is outstanding or the queue is full
  assign accept = (st_q == LS_IDLE) & lreq_i & ~q_full_i;

  always_comb begin
    ctrl             = {lattr_i, 1'b0};
    ctrl[CTL_WR_BIT] = lwrite_i;
  end

  assign push_o   = accept;
  assign entry_o  = {lwdata_i, laddr_i, ctrl};
  assign lack_o   = (accept & lwrite_i) | (st_q == LS_RD_DONE);
  assign lerr_o   = (st_q == LS_RD_DONE) & err_q;
  assign lrdata_o = data_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LS_IDLE:    if (accept && !lwrite_i) st_d = LS_RD_WAIT;
      LS_RD_WAIT: if (rd_done_i) st_d = LS_RD_DONE;
      LS_RD_DONE: st_d = LS_IDLE;
      default:    st_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LS_IDLE;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == LS_RD_WAIT && rd_done_i) begin
        err_q  <= rd_err_i;
        data_q <= rd_data_i;
      end
    end
  end
endmodule

// File: rtl/sbb_sys_issue.sv
module sbb_sys_issue
  import sbb_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 9,
  parameter int unsigned EW = DW + AW + TW + 1
) (
  input  logic          q_empty_i,
  input  logic [EW-1:0] head_i,
  output logic          pop_o,
  output logic          sreq_o,
  output logic          swrite_o,
  output logic [AW-1:0] saddr_o,
  output logic [DW-1:0] swdata_o,
  output logic [TW-1:0] sattr_o,
  input  logic          sready_i,
  input  logic          serr_i,
  input  logic [DW-1:0] srdata_i,
  output logic          rd_done_o,
  output logic          rd_err_o,
  output logic [DW-1:0] rd_data_o
);
  logic [TW:0] ctrl;

  assign ctrl     = head_i[TW:0];
  assign swdata_o = head_i[EW-1 -: DW];
  assign saddr_o  = head_i[EW-DW-1 -: AW];
  assign sattr_o  = ctrl[TW:1];
  assign swrite_o = ctrl[CTL_WR_BIT];
  assign sreq_o   = ~q_empty_i;
  assign pop_o    = sreq_o & sready_i;

  // read data bypasses the queue; errors on posted writes are discarded
  assign rd_done_o = pop_o & ~swrite_o;
  assign rd_err_o  = serr_i;
  assign rd_data_o = srdata_i;
endmodule

// File: rtl/sysbus_post_bridge.sv
module sysbus_post_bridge #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ATTR_W = 9,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lreq_i,
  input  logic              lwrite_i,
  input  logic [ADDR_W-1:0] laddr_i,
  input  logic [DATA_W-1:0] lwdata_i,
  input  logic [ATTR_W-1:0] lattr_i,
  output logic              lack_o,
  output logic              lerr_o,
  output logic [DATA_W-1:0] lrdata_o,
  output logic              sreq_o,
  output logic              swrite_o,
  output logic [ADDR_W-1:0] saddr_o,
  output logic [DATA_W-1:0] swdata_o,
  output logic [ATTR_W-1:0] sattr_o,
  input  logic              sready_i,
  input  logic              serr_i,
  input  logic [DATA_W-1:0] srdata_i
);
  localparam int unsigned CTRL_W  = ATTR_W + 1;
  localparam int unsigned ENTRY_W = DATA_W + ADDR_W + CTRL_W;

  logic               push_w, pop_w, full_w, empty_w;
  logic [ENTRY_W-1:0] entry_w, head_w;
  logic               rd_done_w, rd_err_w;
  logic [DATA_W-1:0]  rd_data_w;

  sbb_local_port #(
    .AW(ADDR_W), .DW(DATA_W), .TW(ATTR_W), .EW(ENTRY_W)
  ) u_local (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lreq_i    (lreq_i),
    .lwrite_i  (lwrite_i),
    .laddr_i   (laddr_i),
    .lwdata_i  (lwdata_i),
    .lattr_i   (lattr_i),
    .lack_o    (lack_o),
    .lerr_o    (lerr_o),
    .lrdata_o  (lrdata_o),
    .q_full_i  (full_w),
    .push_o    (push_w),
    .entry_o   (entry_w),
    .rd_done_i (rd_done_w),
    .rd_err_i  (rd_err_w),
    .rd_data_i (rd_data_w)
  );

  sbb_queue #(.W(ENTRY_W), .DEPTH(DEPTH)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .din_i   (entry_w),
    .pop_i   (pop_w),
    .dout_o  (head_w),
    .full_o  (full_w),
    .empty_o (empty_w)
  );

  sbb_sys_issue #(
    .AW(ADDR_W), .DW(DATA_W), .TW(ATTR_W), .EW(ENTRY_W)
  ) u_issue (
    .q_empty_i (empty_w),
    .head_i    (head_w),
    .pop_o     (pop_w),
    .sreq_o    (sreq_o),
    .swrite_o  (swrite_o),
    .saddr_o   (saddr_o),
    .swdata_o  (swdata_o),
    .sattr_o   (sattr_o),
    .sready_i  (sready_i),
    .serr_i    (serr_i),
    .srdata_i  (srdata_i),
    .rd_done_o (rd_done_w),
    .rd_err_o  (rd_err_w),
    .rd_data_o (rd_data_w)
  );
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ATTR_W = 9,
  parameter int unsigned DEPTH  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lreq_i,
  input logic              lwrite_i,
  input logic              lack_o,
  input logic              lerr_o,
  input logic              sreq_o,
  input logic              sready_i,
  input logic              swrite_o,
  input logic [ADDR_W-1:0] saddr_o,
  input logic [DATA_W-1:0] swdata_o,
  input logic [ATTR_W-1:0] sattr_o,
  input logic              push_w,
  input logic              pop_w
);
  int occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= 0;
    else occ_q <= occ_q + int'(push_w) - int'(pop_w);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!sreq_o);
  end

  assert_ack_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lack_o |-> lreq_i);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == int'(DEPTH)) |-> !push_w);

  assert_bus_idle_when_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == 0) |-> !sreq_o);

  assert_hold_offer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sreq_o && !sready_i) |=> (sreq_o && $stable(saddr_o) && $stable(swdata_o)
                               && $stable(sattr_o) && $stable(swrite_o)));

  assert_write_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lack_o && lwrite_i) |-> !lerr_o);

  assert_read_ack_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lack_o && !lwrite_i) |-> $past(pop_w && !swrite_o));
endmodule

bind sysbus_post_bridge sbb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ATTR_W(ATTR_W), .DEPTH(DEPTH)
) u_sbb_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lreq_i   (lreq_i),
  .lwrite_i (lwrite_i),
  .lack_o   (lack_o),
  .lerr_o   (lerr_o),
  .sreq_o   (sreq_o),
  .sready_i (sready_i),
  .swrite_o (swrite_o),
  .saddr_o  (saddr_o),
  .swdata_o (swdata_o),
  .sattr_o  (sattr_o),
  .push_w   (push_w),
  .pop_w    (pop_w)
);

// File: tb/test_sysbus_post_bridge.sv
module test_sysbus_post_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RD_KEY = 32'hC3C3_0000;

  logic        clk, rst_n;
  logic        lreq, lwrite, lack, lerr;
  logic [31:0] laddr, lwdata, lrdata;
  logic [8:0]  lattr;
  logic        sreq, swrite, sready, serr;
  logic [31:0] saddr, swdata, srdata;
  logic [8:0]  sattr;

  sysbus_post_bridge i_sysbus_post_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .lreq_i(lreq), .lwrite_i(lwrite), .laddr_i(laddr), .lwdata_i(lwdata), .lattr_i(lattr),
    .lack_o(lack), .lerr_o(lerr), .lrdata_o(lrdata),
    .sreq_o(sreq), .swrite_o(swrite), .saddr_o(saddr), .swdata_o(swdata), .sattr_o(sattr),
    .sready_i(sready), .serr_i(serr), .srdata_i(srdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] exp_addr [0:255];
  logic [31:0] exp_data [0:255];
  logic [8:0]  exp_attr [0:255];
  bit          exp_wr   [0:255];
  int exp_cnt = 0, log_cnt = 0;

  bit          cur_wr;
  logic [31:0] cur_addr, cur_data;
  logic [8:0]  cur_attr;

  int rmode = 0;  // 0 ready, 1 stalled, 2 alternate cycles
  int cyc = 0;
  bit          hold_pend = 0;
  logic [31:0] h_addr, h_data;
  logic [8:0]  h_attr;
  bit          h_wr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // system-bus responder and transfer log
  initial begin
    sready = 1'b0; srdata = '0; serr = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      sready = (rmode == 0) || (rmode == 2 && cyc[0]);
      #1;
      srdata = saddr ^ RD_KEY;
      serr   = (saddr[31:28] == 4'hE);
      if (rst_n && sreq) begin
        if (hold_pend) begin
          check(saddr == h_addr && sattr == h_attr && swrite == h_wr && swdata == h_data,
                "R5", "held offer address", saddr, h_addr);
        end
        if (!sready) begin
          hold_pend = 1; h_addr = saddr; h_data = swdata; h_attr = sattr; h_wr = swrite;
        end else begin
          hold_pend = 0;
          if (log_cnt >= exp_cnt) begin
            check(0, "R4", "unexpected transfer index", 32'(log_cnt), 32'(exp_cnt));
          end else begin
            check(saddr == exp_addr[log_cnt], "R4", "transfer address", saddr, exp_addr[log_cnt]);
            check(swrite == exp_wr[log_cnt], "R4", "transfer direction",
                  32'(swrite), 32'(exp_wr[log_cnt]));
            check(sattr == exp_attr[log_cnt], "R4", "transfer attribute",
                  32'(sattr), 32'(exp_attr[log_cnt]));
            if (exp_wr[log_cnt])
              check(swdata == exp_data[log_cnt], "R4", "transfer write data",
                    swdata, exp_data[log_cnt]);
          end
          log_cnt++;
        end
      end else begin
        hold_pend = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 32'(n_chk), 32'(0));
    finish_run();
  end

  task automatic record(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [8:0] t);
    exp_wr[exp_cnt] = wr; exp_addr[exp_cnt] = a; exp_data[exp_cnt] = d; exp_attr[exp_cnt] = t;
    exp_cnt++;
  endtask

  task automatic start_req(input bit wr, input logic [31:0] a, input logic [31:0] d,
                           input logic [8:0] t);
    @(negedge clk);
    cur_wr = wr; cur_addr = a; cur_data = d; cur_attr = t;
    lreq = 1'b1; lwrite = wr; laddr = a; lwdata = d; lattr = t;
    if (!wr) record(0, a, d, t);
  endtask

  task automatic wait_ack(input int maxw, output bit got, output bit err,
                          output logic [31:0] data);
    got = 0; err = 0; data = '0;
    for (int i = 0; i < maxw; i++) begin
      #1;
      if (lack) begin
        got = 1; err = lerr; data = lrdata;
        if (cur_wr) record(1, cur_addr, cur_data, cur_attr);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic end_req();
    @(negedge clk);
    lreq = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && log_cnt != exp_cnt; i++) @(negedge clk);
    check(log_cnt == exp_cnt, req, "all queued transfers issued", 32'(log_cnt), 32'(exp_cnt));
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(!lack && !lerr && !sreq, "R1", "idle outputs after reset",
          {29'd0, lack, lerr, sreq}, 32'd0);
  endtask

  task automatic t_single_write();
    bit got, err; logic [31:0] d;
    rmode = 0;
    start_req(1, 32'h0000_1000, 32'hDEAD_0001, 9'h015);
    wait_ack(1, got, err, d);
    check(got, "R2", "same-cycle write ack", 32'(got), 32'd1);
    check(!err, "R2", "no error with write ack", 32'(err), 32'd0);
    end_req();
    drain("R4");
  endtask

  task automatic t_full_stall();
    bit got, err; logic [31:0] d;
    rmode = 1;
    for (int k = 0; k < 16; k++) begin
      start_req(1, 32'h0000_2000 + 32'(k * 4), 32'hA000_0000 + 32'(k), 9'(k * 7));
      wait_ack(1, got, err, d);
      check(got, "R3", "write accepted below capacity", 32'(got), 32'd1);
      end_req();
    end
    start_req(1, 32'h0000_2FF0, 32'hBEEF_0017, 9'h1A5);
    wait_ack(4, got, err, d);
    check(!got, "R3", "17th write held by full queue", 32'(got), 32'd0);
    rmode = 2;
    wait_ack(200, got, err, d);
    check(got, "R3", "17th write accepted after slot frees", 32'(got), 32'd1);
    end_req();
    drain("R4");
  endtask

  task automatic t_write_err();
    bit got, err; logic [31:0] d;
    rmode = 0;
    start_req(1, 32'hE000_0010, 32'h1234_5678, 9'h0F0);
    wait_ack(1, got, err, d);
    check(got && !err, "R6", "posted write to failing address acks clean",
          {30'd0, got, err}, 32'd2);
    end_req();
    drain("R6");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(!lack && !lerr, "R6", "no late abort after write error",
            {30'd0, lack, lerr}, 32'd0);
    end
  endtask

  task automatic t_read_order();
    bit got, err; logic [31:0] d;
    rmode = 1;
    for (int k = 0; k < 3; k++) begin
      start_req(1, 32'h0000_3000 + 32'(k * 4), 32'h5500_0000 + 32'(k), 9'h101 + 9'(k));
      wait_ack(1, got, err, d);
      end_req();
    end
    start_req(0, 32'h0000_1230, 32'hFFFF_FFFF, 9'h0AA);
    wait_ack(5, got, err, d);
    check(!got, "R7", "read not acked while bus stalled", 32'(got), 32'd0);
    rmode = 2;
    wait_ack(200, got, err, d);
    check(got, "R7", "read acked eventually", 32'(got), 32'd1);
    check(log_cnt == exp_cnt, "R7", "earlier writes and read completed before ack",
          32'(log_cnt), 32'(exp_cnt));
    check(d == (32'h0000_1230 ^ RD_KEY), "R7", "read data from bus", d, 32'h0000_1230 ^ RD_KEY);
    check(!err, "R8", "clean read has no error", 32'(err), 32'd0);
    end_req();
  endtask

  task automatic t_read_err();
    bit got, err; logic [31:0] d;
    rmode = 0;
    start_req(0, 32'hE000_0040, 32'h0, 9'h003);
    wait_ack(20, got, err, d);
    check(got && err, "R8", "read error returned with ack", {30'd0, got, err}, 32'd3);
    end_req();
    start_req(0, 32'h0000_0100, 32'h0, 9'h1FF);
    wait_ack(20, got, err, d);
    check(got && !err && d == (32'h0000_0100 ^ RD_KEY), "R7",
          "read on empty queue returns bus data", d, 32'h0000_0100 ^ RD_KEY);
    end_req();
  endtask

  initial begin
    rst_n = 1'b0; lreq = 1'b0; lwrite = 1'b0; laddr = '0; lwdata = '0; lattr = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!sreq && !lack && !lerr, "R1", "outputs during reset",
          {29'd0, sreq, lack, lerr}, 32'd0);
    rst_n = 1'b1;
    t_reset();
    t_single_write();
    t_full_stall();
    t_write_err();
    t_read_order();
    t_read_err();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule